// File: doc/BRIEF.md
# I2C SCL and Bus-Condition Timing Generator

This block produces the clock-line and data-line drive enables for an I2C master. A byte-level engine above it asks for one bus action at a time: a START condition, a single data bit, a STOP condition or a repeated START. The block then produces that action with the phase lengths programmed in its timing words. A drive enable of 1 pulls the open-drain line low. A value of 0 releases the line.

All phase lengths are counted in prescaled ticks. One tick lasts DIV+1 input clocks. Each edge of SCL also costs a fixed guard interval of 4+F input clocks, where F is the input-filter cycle count. An undisturbed bit therefore lasts (DIV+1)·(T_LOW+T_HIGH+2) + 8 + 2·F input clocks. A target device may stretch the clock by holding SCL low after the block releases it. The high-time count does not start until the line is seen high.

After the engine issues a command, the block drops `req_ready`. When the action is complete it pulses `done` and raises `req_ready` again. The block then rests either idle, with both lines released, or holding SCL low between bits.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, `req_ready` is 1 and `done` is 0.
- R2: START (command code 0) is taken only when the bus is idle. SDA is pulled low su'·(DIV+1) clocks after the accepting edge, where su' comes from `tim_a[31:24]`. SCL is pulled low hd'·(DIV+1) clocks later, where hd' comes from `tim_a[23:16]`.
- R3: In a data bit, SCL is held low for OVH + LL·(DIV+1) clocks and released for OVH + (T_HIGH+1)·(DIV+1) clocks. Here OVH = 4 + `filt_cnt`, T_LOW = `tim_b[15:8]`, T_HIGH = `tim_b[7:0]`, and LL = max(T_LOW+1, hold'+setup'). This assumes the engine answers `done` at once.
- R4: In a bit (command code 1), SDA takes its new value hold'·(DIV+1) clocks after the low phase starts, where hold' comes from `hold_cnt`. `req_bit`=1 releases SDA (`sda_oe`=0) and `req_bit`=0 drives it low. SDA never changes in the cycle SCL falls or the cycle after.
- R5: The data setup count setup' from `tim_b[31:24]` lengthens the low phase, when needed, so that SDA is stable for at least setup' ticks before SCL is released.
- R6: If SCL reads low after release (clock stretching), the guard interval and the high time start only once `scl_in` reads high. The released span grows by the stretch length.
- R7: STOP (command code 2) drives SDA low during the low phase and then releases SCL. It releases SDA OVH + sto'·(DIV+1) clocks after the SCL release, where sto' comes from `tim_a[15:8]`, and returns to idle.
- R8: Repeated START (command code 3) releases SDA during the low phase. It keeps SCL low for a further rel'·(DIV+1) clocks, where rel' comes from `tim_c[7:0]`, then releases SCL. After that it forms a START: SDA falls OVH + su'·(DIV+1) clocks after the SCL release.
- R9: Any start, stop, setup, hold or release count of zero lasts one tick.
- R10: A START while SCL is held, or a bit, STOP or repeated START while idle, is consumed with no effect. Both drive enables stay unchanged, `done` stays 0 and `req_ready` stays 1.
- R11: The prescaler value DIV sits in `tim_c[23:16]` and makes one tick last DIV+1 input clocks, from 1 to 256.
- R12: `req_ready` is 1 only while idle or holding SCL low between actions, and falls only when a command is accepted. `done` is a one-cycle pulse at the end of each accepted action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_a | input | 32 | START setup [31:24], START hold [23:16], STOP setup [15:8] |
| tim_b | input | 32 | Data setup [31:24], SCL low [15:8], SCL high [7:0] |
| tim_c | input | 32 | Prescaler DIV [23:16], repeated-start release [7:0] |
| hold_cnt | input | 8 | Data hold count |
| filt_cnt | input | 3 | Input filter cycles, adds to the per-edge guard interval |
| req_valid | input | 1 | Engine presents a command |
| req_cmd | input | 2 | 0 START, 1 bit, 2 STOP, 3 repeated START |
| req_bit | input | 1 | Data bit value for command 1 |
| req_ready | output | 1 | Block can take a command |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Drive SCL low |
| sda_oe | output | 1 | Drive SDA low |
| done | output | 1 | Action finished pulse |

## Verification
The assertions assume three things about the inputs. The timing words and filter count change only while the block is idle. The SCL line reads high whenever the block has released it, apart from a stretch that begins right at a release. Nothing else holds SCL low during a START setup or hold.

The stimulus follows these rules. It changes the configuration only between STOP and the next START. It drives `scl_in` as the wired-AND of the block's own drive and one stretch flag. It raises that flag only around a bit, and lowers it a set number of cycles after the release.

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int FLTW     = 3,
  parameter int OVH_BASE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     tim_a,
  input  logic [31:0]     tim_b,
  input  logic [31:0]     tim_c,
  input  logic [7:0]      hold_cnt,
  input  logic [FLTW-1:0] filt_cnt,
  input  logic            req_valid,
  input  logic [1:0]      req_cmd,
  input  logic            req_bit,
  output logic            req_ready,
  input  logic            scl_in,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            done
);
  localparam int FW = 8;
  localparam int TW = FW + 2;
  localparam int OW = $clog2(OVH_BASE + (1 << FLTW));
  localparam logic [1:0] C_START = 2'd0, C_BIT = 2'd1, C_STOP = 2'd2, C_RSTART = 2'd3;

  typedef enum logic [3:0] {IDLE, SSU, SHD, FALL, HOLD, LOW, REL, RISE, HIGH, PSU} st_t;
  st_t st, st_n;

  logic [1:0]    cur;
  logic          tgt;
  logic [FW-1:0] pre;
  logic [TW-1:0] tcnt, len;
  logic [OW-1:0] ocnt;

  function automatic logic [TW-1:0] nz(input logic [FW-1:0] v);
    return (v == '0) ? TW'(1) : TW'(v);
  endfunction

  wire [FW-1:0] div     = tim_c[23:16];
  wire [TW-1:0] hold_t  = nz(hold_cnt);
  wire [TW-1:0] low_min = TW'(tim_b[15:8]) + TW'(1);
  wire [TW-1:0] hs_sum  = hold_t + nz(tim_b[31:24]);
  wire [TW-1:0] low_len = (hs_sum > low_min) ? hs_sum : low_min;
  wire [OW-1:0] ovh     = OW'(OVH_BASE) + OW'(filt_cnt);
  wire          tick    = (pre == div);

  logic unused_bits;
  assign unused_bits = ^{tim_a[7:0], tim_b[23:16], tim_c[31:24], tim_c[15:8]};

  always_comb begin
    case (st)
      SSU:     len = nz(tim_a[31:24]);
      SHD:     len = nz(tim_a[23:16]);
      PSU:     len = nz(tim_a[15:8]);
      REL:     len = nz(tim_c[7:0]);
      LOW:     len = low_len;
      HIGH:    len = TW'(tim_b[7:0]) + TW'(1);
      default: len = '1;
    endcase
  end

  wire ph_end = tick && (tcnt == len - TW'(1));
  assign req_ready = (st == IDLE) || (st == HOLD);
  wire legal = (st == IDLE) ? (req_cmd == C_START) : (req_cmd != C_START);
  wire take  = req_valid && req_ready && legal;

  always_comb begin
    st_n = st;
    case (st)
      IDLE, HOLD: if (take) st_n = (req_cmd == C_START) ? SSU : LOW;
      SSU:  if (ph_end) st_n = SHD;
      SHD:  if (ph_end) st_n = FALL;
      FALL: if (ocnt == ovh - OW'(2)) st_n = HOLD;
      LOW:  if (ph_end) st_n = (cur == C_RSTART) ? REL : RISE;
      REL:  if (ph_end) st_n = RISE;
      RISE: if (scl_in && ocnt == ovh - OW'(1))
              st_n = (cur == C_BIT) ? HIGH : (cur == C_STOP) ? PSU : SSU;
      HIGH: if (ph_end) st_n = FALL;
      PSU:  if (ph_end) st_n = IDLE;
      default: st_n = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cur    <= C_START;
      tgt    <= 1'b0;
      pre    <= '0;
      tcnt   <= '0;
      ocnt   <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
    end else begin
      st   <= st_n;
      done <= (st_n != st) && (st_n == HOLD || st_n == IDLE);
      if (st_n != st) begin
        pre  <= '0;
        tcnt <= '0;
        ocnt <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) tcnt <= tcnt + 1'b1;
        if (st == RISE && !scl_in) ocnt <= '0;
        else                       ocnt <= ocnt + 1'b1;
      end
      if (take) begin
        cur <= req_cmd;
        tgt <= (req_cmd == C_BIT) ? ~req_bit : (req_cmd == C_STOP);
      end
      if (st == LOW && tick && tcnt == hold_t - TW'(1)) sda_oe <= tgt;
      if (st == SSU && st_n == SHD)  sda_oe <= 1'b1;
      if (st == PSU && st_n == IDLE) sda_oe <= 1'b0;
      if ((st == SHD || st == HIGH) && st_n == FALL) scl_oe <= 1'b1;
      if (st != RISE && st_n == RISE) scl_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_in,
  input logic       done,
  input logic       req_ready,
  input logic       req_valid,
  input logic [1:0] req_cmd
);
  assert_hold_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $stable(sda_oe));
  assert_hold_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |=> $stable(sda_oe));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !scl_oe) |-> !sda_oe);
  assert_bad_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && ((!scl_oe && req_cmd != 2'd0) || (scl_oe && req_cmd == 2'd0)))
    |=> (req_ready && $stable(scl_oe) && $stable(sda_oe) && !done));
  assert_high_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(scl_in));
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in),
  .done(done), .req_ready(req_ready), .req_valid(req_valid), .req_cmd(req_cmd)
);

// File: tb/tb_scl_phase_gen.sv
module tb_scl_phase_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] su_sta, hd_sta, su_sto, su_dat, lo, hi, dv, rel, hd_dat;
  logic [2:0] flt;
  logic       req_valid = 1'b0, req_bit = 1'b0, stretch = 1'b0;
  logic [1:0] req_cmd = 2'd0;
  logic       req_ready, scl_oe, sda_oe, done, scl_in;

  assign scl_in = !(scl_oe || stretch);
  wire [31:0] tim_a = {su_sta, hd_sta, su_sto, 8'h00};
  wire [31:0] tim_b = {su_dat, 8'h00, lo, hi};
  wire [31:0] tim_c = {8'h00, dv, 8'h00, rel};

  scl_phase_gen dut (
    .clk(clk), .rst_n(rst_n), .tim_a(tim_a), .tim_b(tim_b), .tim_c(tim_c),
    .hold_cnt(hd_dat), .filt_cnt(flt), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bit(req_bit), .req_ready(req_ready), .scl_in(scl_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .done(done)
  );

  int nchk = 0, nfail = 0;
  bit qs[$];
  bit qd[$];
  int qt[$];
  string qg[$];
  bit m_scl = 1'b0, m_sda = 1'b0, acc_ok = 1'b0;
  int acc = 0;
  string ctag = "R11";

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nzi(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction
  function automatic int d1();
    return int'(dv) + 1;
  endfunction
  function automatic int ovh();
    return 4 + int'(flt);
  endfunction
  function automatic int lowlen();
    int a = int'(lo) + 1;
    int b = nzi(hd_dat) + nzi(su_dat);
    return (a > b) ? a : b;
  endfunction

  task automatic push_ev(input bit s, input bit d, input string tag);
    if (s != m_scl || d != m_sda) begin
      qs.push_back(s); qd.push_back(d); qg.push_back({tag, " ", ctag});
      qt.push_back(acc_ok ? acc : -1);
      acc = 0; acc_ok = 1'b1; m_scl = s; m_sda = d;
    end
  endtask

  task automatic m_start();
    acc += nzi(su_sta) * d1(); push_ev(1'b0, 1'b1, "R2 start sda");
    acc += nzi(hd_sta) * d1(); push_ev(1'b1, 1'b1, "R2 start scl");
    acc += ovh();
  endtask

  task automatic m_bit(input bit b, input int s);
    acc += nzi(hd_dat) * d1(); push_ev(1'b1, !b, "R4 data hold");
    acc += (lowlen() - nzi(hd_dat)) * d1(); push_ev(1'b0, m_sda, "R3 low span");
    acc += s + ovh() + (int'(hi) + 1) * d1();
    push_ev(1'b1, m_sda, (s > 0) ? "R6 stretched high" : "R3 high span");
    acc += ovh();
  endtask

  task automatic m_stop();
    acc += nzi(hd_dat) * d1(); push_ev(1'b1, 1'b1, "R7 stop sda low");
    acc += (lowlen() - nzi(hd_dat)) * d1(); push_ev(1'b0, 1'b1, "R7 stop scl");
    acc += ovh() + nzi(su_sto) * d1(); push_ev(1'b0, 1'b0, "R7 stop sda");
    acc_ok = 1'b0;
  endtask

  task automatic m_restart();
    acc += nzi(hd_dat) * d1(); push_ev(1'b1, 1'b0, "R8 restart sda high");
    acc += (lowlen() - nzi(hd_dat)) * d1() + nzi(rel) * d1();
    push_ev(1'b0, 1'b0, "R8 restart release");
    acc += ovh() + nzi(su_sta) * d1(); push_ev(1'b0, 1'b1, "R8 restart sda");
    acc += nzi(hd_sta) * d1(); push_ev(1'b1, 1'b1, "R8 restart scl");
    acc += ovh();
  endtask

  task automatic do_cmd(input logic [1:0] c, input logic b);
    req_cmd = c; req_bit = b; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 ready low while busy", int'(req_ready), 0);
    while (!done) @(negedge clk);
  endtask

  task automatic do_bad(input logic [1:0] c);
    if (m_scl) acc += 1;
    req_cmd = c; req_bit = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 ready kept", int'(req_ready), 1);
    check("R10 no done", int'(done), 0);
    check("R10 scl unchanged", int'(scl_oe), int'(m_scl));
    check("R10 sda unchanged", int'(sda_oe), int'(m_sda));
  endtask

  task automatic stretch_it(input int n);
    stretch = 1'b1;
    do @(negedge clk); while (scl_oe);
    repeat (n) @(negedge clk);
    stretch = 1'b0;
  endtask

  task automatic run_seq();
    m_start();      do_cmd(2'd0, 1'b0);
    do_bad(2'd0);
    m_bit(1'b1, 0); do_cmd(2'd1, 1'b1);
    m_bit(1'b0, 0); do_cmd(2'd1, 1'b0);
    m_bit(1'b0, 5);
    fork
      do_cmd(2'd1, 1'b0);
      stretch_it(5);
    join
    m_bit(1'b1, 0); do_cmd(2'd1, 1'b1);
    m_restart();    do_cmd(2'd3, 1'b0);
    m_bit(1'b0, 0); do_cmd(2'd1, 1'b0);
    m_stop();       do_cmd(2'd2, 1'b0);
    do_bad(2'd1);
    do_bad(2'd2);
  endtask

  initial begin
    int cnt = 0;
    logic [1:0] prev = 2'b00;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cnt++;
        if ({scl_oe, sda_oe} != prev) begin
          if (qs.size() == 0) begin
            check("R12 unexpected edge", int'({scl_oe, sda_oe}), int'(prev));
          end else begin
            bit es, ed;
            int et;
            string tg;
            es = qs.pop_front(); ed = qd.pop_front(); et = qt.pop_front(); tg = qg.pop_front();
            check({tg, " level"}, int'({scl_oe, sda_oe}), int'({es, ed}));
            if (et >= 0) check({tg, " interval"}, cnt, et);
          end
          prev = {scl_oe, sda_oe};
          cnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    dv = 8'd1; flt = 3'd0; lo = 8'd5; hi = 8'd4; su_sta = 8'd3; hd_sta = 8'd2;
    su_sto = 8'd3; hd_dat = 8'd2; su_dat = 8'd1; rel = 8'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 scl_oe at reset", int'(scl_oe), 0);
    check("R1 sda_oe at reset", int'(sda_oe), 0);
    check("R1 ready at reset", int'(req_ready), 1);
    check("R1 done at reset", int'(done), 0);
    ctag = "R11";
    run_seq();

    dv = 8'd0; flt = 3'd7; lo = 8'd0; hi = 8'd0; su_sta = 8'd0; hd_sta = 8'd0;
    su_sto = 8'd0; hd_dat = 8'd0; su_dat = 8'd0; rel = 8'd0;
    ctag = "R9";
    @(negedge clk);
    run_seq();

    dv = 8'd2; flt = 3'd3; lo = 8'd2; hi = 8'd1; su_sta = 8'd1; hd_sta = 8'd1;
    su_sto = 8'd2; hd_dat = 8'd3; su_dat = 8'd4; rel = 8'd0;
    ctag = "R5";
    @(negedge clk);
    run_seq();

    repeat (5) @(negedge clk);
    check("R12 all expected edges seen", qs.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule